// File: doc/BRIEF.md
# Time-Matched Periodic Pulse Generator

This block keeps a local time of day as 32-bit seconds and 30-bit nanoseconds and compares it every clock with a programmed target time. When the local time reaches or passes the target, the block drives a pulse of a coded width on its output pin. In periodic mode the target is then moved forward by a programmed reload period, so a pulse train follows. In hold mode the target stays where it is, and only one pulse is produced.

Software sets up the block through a plain 16-bit register port. It writes a configuration word, the target time and the reload period, each of the last two as four 16-bit halves. A step input loads a new absolute time into the counter. On a step the block moves the target to the new whole second plus two with zero nanoseconds, so that pulse generation starts again from a clean point. Output is switched off by parking the target seconds at all ones while hold mode is selected.

Top module: `ppg_pulse_gen`

## Requirements
- R1: Register map on `addr_i`: 0 configuration (all 16 bits stored), 1 target ns low, 2 target ns high, 3 target seconds low, 4 target seconds high, 5 reload ns low, 6 reload ns high, 7 reload seconds low, 8 reload seconds high. Both ns-high registers keep only bits 13:0 and read back with bits 15:14 as zero. Any other address reads zero. `rdata_o` is a combinational read of the register selected by `addr_i`, and a write takes effect at the clock edge where `wr_en_i` is high.
- R2: The time counter adds NS_PER_CLK nanoseconds each clock. When the nanoseconds reach 1,000,000,000 they wrap and the seconds increase by one.
- R3: A match occurs when the local time is greater than or equal to the target time. The pulse becomes active in the cycle after the match.
- R4: Configuration bits 7:4 hold the width code. Codes 0 to 13 give 100 ns, 500 ns, 1 us, 5 us, 10 us, 50 us, 100 us, 500 us, 1 ms, 5 ms, 10 ms, 50 ms, 100 ms and 200 ms. Codes 14 and 15 give 200 ms. The pulse stays active for ceil(width / NS_PER_CLK) cycles.
- R5: When configuration bit 0 is clear, each match adds the reload period to the target. The target nanoseconds wrap at one second and carry into the seconds.
- R6: When configuration bit 0 is set, a match leaves the target unchanged, and exactly one pulse is produced until the target is written or a step occurs.
- R7: When configuration bit 1 is set, the pulse is active-high and the idle level is 0. When bit 1 is clear, the pulse is active-low and the idle level is 1.
- R8: A reload period below 200 ns (seconds zero and ns less than 200) raises `period_err_o`, and no match then starts a pulse. A reload of exactly 200 ns is legal.
- R9: With target seconds at 0xFFFFFFFF and hold mode selected, no pulse is produced.
- R10: A step loads `step_sec_i`/`step_ns_i` into the time counter and sets the target to `step_sec_i`+2 seconds and 0 ns.
- R11: A match while a pulse is active restarts the width timer, and the output stays active without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| step_en_i | input | 1 | Load a new absolute time |
| step_sec_i | input | 32 | Seconds to load on a step |
| step_ns_i | input | 30 | Nanoseconds to load on a step |
| pulse_o | output | 1 | Pulse output, polarity as configured |
| period_err_o | output | 1 | Reload period is below the legal minimum |

## Verification
The bench builds the block with NS_PER_CLK set to 100. With that value the short width codes last 1, 5, 10 and 50 cycles, and a reload of 1000 ns gives a 10-cycle pulse spacing that can be measured exactly. Steps to a time just before a second boundary bring the nanosecond wrap of both the counter and the reload adder within a few hundred cycles. Widths of a millisecond and above would take too many cycles at this setting, so the bench reaches them only through the shared width table logic.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam logic [30:0] NS_PER_SEC = 31'd1_000_000_000;

  typedef struct packed {
    logic [31:0] sec;
    logic [29:0] ns;
  } ppg_time_t;

  typedef enum logic [3:0] {
    REG_CFG     = 4'd0,
    REG_TNS_LO  = 4'd1,
    REG_TNS_HI  = 4'd2,
    REG_TSEC_LO = 4'd3,
    REG_TSEC_HI = 4'd4,
    REG_RNS_LO  = 4'd5,
    REG_RNS_HI  = 4'd6,
    REG_RSEC_LO = 4'd7,
    REG_RSEC_HI = 4'd8
  } ppg_addr_e;

  // Active time in ns for each width code; codes above 13 use the longest.
  function automatic logic [27:0] width_ns(input logic [3:0] code);
    case (code)
      4'd0:    width_ns = 28'd100;
      4'd1:    width_ns = 28'd500;
      4'd2:    width_ns = 28'd1_000;
      4'd3:    width_ns = 28'd5_000;
      4'd4:    width_ns = 28'd10_000;
      4'd5:    width_ns = 28'd50_000;
      4'd6:    width_ns = 28'd100_000;
      4'd7:    width_ns = 28'd500_000;
      4'd8:    width_ns = 28'd1_000_000;
      4'd9:    width_ns = 28'd5_000_000;
      4'd10:   width_ns = 28'd10_000_000;
      4'd11:   width_ns = 28'd50_000_000;
      4'd12:   width_ns = 28'd100_000_000;
      default: width_ns = 28'd200_000_000;
    endcase
  endfunction

endpackage

// File: rtl/ppg_time_counter.sv
module ppg_time_counter
  import ppg_pkg::*;
#(
  parameter int unsigned NS_PER_CLK = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_en,
  input  ppg_time_t step_time,
  output ppg_time_t now
);
  localparam logic [30:0] INC = 31'(NS_PER_CLK);

  logic [30:0] ns_sum;
  assign ns_sum = {1'b0, now.ns} + INC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '0;
    end else if (step_en) begin
      now <= step_time;
    end else if (ns_sum >= NS_PER_SEC) begin
      now.ns  <= 30'(ns_sum - NS_PER_SEC);
      now.sec <= now.sec + 32'd1;
    end else begin
      now.ns <= ns_sum[29:0];
    end
  end
endmodule

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int unsigned LEAD_SEC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        step_en,
  input  logic [31:0] step_sec,
  input  logic        advance,
  output logic [15:0] cfg,
  output ppg_time_t   target,
  output ppg_time_t   reload,
  output logic        tgt_touched
);
  localparam logic [31:0] LEAD = 32'(LEAD_SEC);

  logic        tgt_wr;
  logic [30:0] add_ns;
  ppg_time_t   next_tgt;

  assign tgt_wr = wr_en && (addr inside {REG_TNS_LO, REG_TNS_HI, REG_TSEC_LO, REG_TSEC_HI});
  assign tgt_touched = step_en || tgt_wr || advance;

  // Reload adder with wrap of the nanoseconds at one second.
  assign add_ns = {1'b0, target.ns} + {1'b0, reload.ns};
  always_comb begin
    if (add_ns >= NS_PER_SEC) begin
      next_tgt.ns  = 30'(add_ns - NS_PER_SEC);
      next_tgt.sec = target.sec + reload.sec + 32'd1;
    end else begin
      next_tgt.ns  = add_ns[29:0];
      next_tgt.sec = target.sec + reload.sec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= 16'h0003;
      target <= '{sec: 32'hFFFF_FFFF, ns: 30'd0};
      reload <= '0;
    end else begin
      if (step_en) begin
        target <= '{sec: step_sec + LEAD, ns: 30'd0};
      end else if (tgt_wr) begin
        case (addr)
          REG_TNS_LO:  target.ns[15:0]   <= wdata;
          REG_TNS_HI:  target.ns[29:16]  <= wdata[13:0];
          REG_TSEC_LO: target.sec[15:0]  <= wdata;
          default:     target.sec[31:16] <= wdata;
        endcase
      end else if (advance) begin
        target <= next_tgt;
      end
      if (wr_en) begin
        case (addr)
          REG_CFG:     cfg               <= wdata;
          REG_RNS_LO:  reload.ns[15:0]   <= wdata;
          REG_RNS_HI:  reload.ns[29:16]  <= wdata[13:0];
          REG_RSEC_LO: reload.sec[15:0]  <= wdata;
          REG_RSEC_HI: reload.sec[31:16] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      REG_CFG:     rdata = cfg;
      REG_TNS_LO:  rdata = target.ns[15:0];
      REG_TNS_HI:  rdata = {2'b00, target.ns[29:16]};
      REG_TSEC_LO: rdata = target.sec[15:0];
      REG_TSEC_HI: rdata = target.sec[31:16];
      REG_RNS_LO:  rdata = reload.ns[15:0];
      REG_RNS_HI:  rdata = {2'b00, reload.ns[29:16]};
      REG_RSEC_LO: rdata = reload.sec[15:0];
      REG_RSEC_HI: rdata = reload.sec[31:16];
      default:     rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/ppg_width_timer.sv
module ppg_width_timer
  import ppg_pkg::*;
#(
  parameter int unsigned NS_PER_CLK = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [3:0] code,
  output logic       active
);
  localparam logic [27:0] DEC = 28'(NS_PER_CLK);

  logic [27:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (fire) begin
      remain <= width_ns(code);
    end else if (remain > DEC) begin
      remain <= remain - DEC;
    end else begin
      remain <= '0;
    end
  end

  assign active = (remain != '0);
endmodule

// File: rtl/ppg_pulse_gen.sv
module ppg_pulse_gen
  import ppg_pkg::*;
#(
  parameter int unsigned NS_PER_CLK    = 8,
  parameter int unsigned MIN_PERIOD_NS = 200,
  parameter int unsigned LEAD_SEC      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        step_en_i,
  input  logic [31:0] step_sec_i,
  input  logic [29:0] step_ns_i,
  output logic        pulse_o,
  output logic        period_err_o
);
  localparam logic [29:0] MIN_NS = 30'(MIN_PERIOD_NS);

  ppg_time_t   now;
  ppg_time_t   target;
  ppg_time_t   reload;
  logic [15:0] cfg;
  logic        hold;
  logic        active_high;
  logic        reached;
  logic        fired;
  logic        match;
  logic        tgt_touched;
  logic        active;

  assign hold        = cfg[0];
  assign active_high = cfg[1];

  ppg_time_counter #(.NS_PER_CLK(NS_PER_CLK)) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en_i),
    .step_time ('{sec: step_sec_i, ns: step_ns_i}),
    .now       (now)
  );

  ppg_regs #(.LEAD_SEC(LEAD_SEC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en_i),
    .addr        (addr_i),
    .wdata       (wdata_i),
    .rdata       (rdata_o),
    .step_en     (step_en_i),
    .step_sec    (step_sec_i),
    .advance     (match && !hold),
    .cfg         (cfg),
    .target      (target),
    .reload      (reload),
    .tgt_touched (tgt_touched)
  );

  // Greater-or-equal compare so a time that jumps past the target still fires.
  assign reached = (now.sec > target.sec) ||
                   ((now.sec == target.sec) && (now.ns >= target.ns));
  assign period_err_o = (reload.sec == 32'd0) && (reload.ns < MIN_NS);
  assign match = reached && !fired && !period_err_o;

  // In hold mode a target fires once; any change of target re-arms it.
  always_ff @(posedge clk) begin
    if (!rst_n)           fired <= 1'b0;
    else if (tgt_touched) fired <= 1'b0;
    else if (match)       fired <= 1'b1;
  end

  ppg_width_timer #(.NS_PER_CLK(NS_PER_CLK)) u_width (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (match),
    .code   (cfg[7:4]),
    .active (active)
  );

  assign pulse_o = active_high ? active : !active;
endmodule

// File: rtl/ppg_pulse_gen_chk.sv
module ppg_pulse_gen_chk #(
  parameter int unsigned LEAD_SEC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en_i,
  input logic [31:0] step_sec_i,
  input logic        wr_en_i,
  input logic        match,
  input logic        hold,
  input logic        active,
  input logic        period_err_o,
  input logic [31:0] tgt_sec,
  input logic [29:0] tgt_ns,
  input logic [29:0] now_ns
);
  AST_NS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en_i |=> (now_ns < 30'd1_000_000_000)); // R2

  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> active); // R3

  AST_RELOAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !hold && !step_en_i && !wr_en_i) |=>
      ({tgt_sec, tgt_ns} != $past({tgt_sec, tgt_ns}))); // R5

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (match && hold && !step_en_i && !wr_en_i) |=>
      ($stable(tgt_sec) && $stable(tgt_ns))); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period_err_o && !active) |=> !active); // R8

  AST_STEP_RETARGET: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i |=> ((tgt_sec == $past(step_sec_i) + 32'(LEAD_SEC)) && (tgt_ns == 30'd0))); // R10

  AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (active && match) |=> active); // R11
endmodule

bind ppg_pulse_gen ppg_pulse_gen_chk #(.LEAD_SEC(LEAD_SEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_en_i    (step_en_i),
  .step_sec_i   (step_sec_i),
  .wr_en_i      (wr_en_i),
  .match        (match),
  .hold         (hold),
  .active       (active),
  .period_err_o (period_err_o),
  .tgt_sec      (target.sec),
  .tgt_ns       (target.ns),
  .now_ns       (now.ns)
);

// File: tb/ppg_pulse_gen_tb_top.sv
module ppg_pulse_gen_tb_top;
  localparam int unsigned NS = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = 4'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rdata_o;
  logic        step_en_i = 1'b0;
  logic [31:0] step_sec_i = 32'd0;
  logic [29:0] step_ns_i = 30'd0;
  logic        pulse_o;
  logic        period_err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ppg_pulse_gen #(.NS_PER_CLK(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .step_en_i(step_en_i),
    .step_sec_i(step_sec_i), .step_ns_i(step_ns_i),
    .pulse_o(pulse_o), .period_err_o(period_err_o)
  );

  // {address, write data, expected read data}
  localparam int NVEC = 11;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0,  16'h0013, 16'h0013},
    {4'd1,  16'h1234, 16'h1234},
    {4'd2,  16'hFFFF, 16'h3FFF},
    {4'd3,  16'hABCD, 16'hABCD},
    {4'd4,  16'h5A5A, 16'h5A5A},
    {4'd5,  16'h0F0F, 16'h0F0F},
    {4'd6,  16'hC001, 16'h0001},
    {4'd7,  16'h7777, 16'h7777},
    {4'd8,  16'h8001, 16'h8001},
    {4'd9,  16'hBEEF, 16'h0000},
    {4'd15, 16'h1111, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_step(input logic [31:0] s, input logic [29:0] n);
    @(negedge clk);
    step_en_i = 1'b1; step_sec_i = s; step_ns_i = n;
    @(negedge clk);
    step_en_i = 1'b0;
  endtask

  // Watch n cycles; count active samples, rises, first two rise indices, first run length.
  task automatic observe(input int n, input logic act, output int highs, output int rises,
                         output int r1, output int r2, output int run1);
    logic prev;
    logic cur;
    bit   in_run;
    highs = 0; rises = 0; r1 = -1; r2 = -1; run1 = 0; in_run = 1'b0;
    prev = (pulse_o == act);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = (pulse_o == act);
      if (cur) highs++;
      if (cur && !prev) begin
        rises++;
        if (r1 < 0) begin r1 = i; in_run = 1'b1; end
        else if (r2 < 0) r2 = i;
      end
      if (in_run) begin
        if (cur) run1++;
        else in_run = 1'b0;
      end
      prev = cur;
    end
  endtask

  task automatic park();
    wr(4'd4, 16'hFFFF);
    wr(4'd3, 16'hFFFF);
    wr(4'd0, 16'h0003);
    repeat (60) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int h, r, r1, r2, run;
    int widths [4] = '{1, 5, 10, 50};
    int cnt;

    repeat (4) @(negedge clk);
    // Reset state
    check(pulse_o == 1'b0, "R7 reset idle", pulse_o, 0);
    check(period_err_o == 1'b1, "R8 reset reload", period_err_o, 1);
    rd(4'd4, d); check(d == 16'hFFFF, "R9 reset target parked", d, 16'hFFFF);
    rd(4'd0, d); check(d == 16'h0003, "R1 reset cfg", d, 3);
    rst_n = 1'b1;

    // R1: register vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], d);
      check(d == VEC[i][15:0], "R1 register readback", d, VEC[i][15:0]);
    end
    for (int a = 5; a <= 8; a++) wr(4'(a), 16'h0000);

    // R10: step retargets to step seconds + 2, ns 0
    do_step(32'd70, 30'd12345);
    rd(4'd3, d); check(d == 16'd72, "R10 target seconds", d, 72);
    rd(4'd4, d); check(d == 16'd0, "R10 target seconds high", d, 0);
    rd(4'd1, d); check(d == 16'd0, "R10 target ns", d, 0);

    // R4/R6/R3: single pulses in hold mode, one per width code
    wr(4'd5, 16'd1000);
    check(period_err_o == 1'b0, "R8 legal reload", period_err_o, 0);
    for (int c = 0; c < 4; c++) begin
      do_step(32'd100 + 32'(c), 30'd0);
      wr(4'd0, 16'((c << 4) | 3));
      wr(4'd3, 16'd0);
      observe(80, 1'b1, h, r, r1, r2, run);
      check(h == widths[c], "R4 width code", h, widths[c]);
      check(r == 1, "R6 one pulse in hold", r, 1);
      rd(4'd3, d); check(d == 16'd0, "R6 target unchanged", d, 0);
    end

    // R7: active-low
    do_step(32'd80, 30'd0);
    wr(4'd0, 16'h0001);
    check(pulse_o == 1'b1, "R7 idle high when bit1 clear", pulse_o, 1);
    wr(4'd3, 16'd0);
    observe(20, 1'b0, h, r, r1, r2, run);
    check(h == 1 && r == 1, "R7 low-going pulse", h, 1);
    wr(4'd0, 16'h0003);
    check(pulse_o == 1'b0, "R7 idle low when bit1 set", pulse_o, 0);

    // R2/R3: counter wrap into the next second reaches target (10, 200)
    do_step(32'd9, 30'd999_990_000);
    wr(4'd1, 16'd200);
    wr(4'd3, 16'd10);
    observe(85, 1'b1, h, r, r1, r2, run);
    check(r == 0, "R3 no early match", r, 0);
    observe(40, 1'b1, h, r, r1, r2, run);
    check(r == 1, "R2 seconds carry reaches target", r, 1);

    // R5: periodic spacing with reload 1000 ns, width 500 ns
    do_step(32'd30, 30'd0);
    wr(4'd5, 16'd1000); wr(4'd6, 16'd0); wr(4'd7, 16'd0);
    wr(4'd0, 16'h0012);
    wr(4'd1, 16'd3000);
    wr(4'd3, 16'd30);
    observe(80, 1'b1, h, r, r1, r2, run);
    check(r2 - r1 == 10, "R5 pulse spacing", r2 - r1, 10);
    check(run == 5, "R5 pulse width in train", run, 5);

    // R9: park the target
    park();
    observe(200, 1'b1, h, r, r1, r2, run);
    check(h == 0, "R9 parked target silent", h, 0);

    // R5: reload adder wraps ns and carries
    do_step(32'd20, 30'd0);
    wr(4'd5, 16'(999_999_900 & 32'hFFFF));
    wr(4'd6, 16'(999_999_900 >> 16));
    wr(4'd0, 16'h0002);
    wr(4'd1, 16'd1500);
    wr(4'd3, 16'd20);
    observe(40, 1'b1, h, r, r1, r2, run);
    check(r == 1, "R5 single match before far reload", r, 1);
    rd(4'd3, d); check(d == 16'd21, "R5 carry into seconds", d, 21);
    rd(4'd1, d); check(d == 16'd1400, "R5 wrapped ns", d, 1400);
    rd(4'd2, d); check(d == 16'd0, "R5 wrapped ns high", d, 0);
    park();

    // R11: 5 us width with 1000 ns period stays asserted
    do_step(32'd50, 30'd0);
    wr(4'd5, 16'd1000); wr(4'd6, 16'd0);
    wr(4'd0, 16'h0032);
    wr(4'd1, 16'd2000);
    wr(4'd3, 16'd50);
    cnt = 0;
    while (pulse_o != 1'b1 && cnt < 60) begin @(negedge clk); cnt++; end
    observe(150, 1'b1, h, r, r1, r2, run);
    check(h == 150, "R11 no gap on retrigger", h, 150);
    park();

    // R8: illegal reload blocks pulses, 200 ns is legal
    do_step(32'd40, 30'd0);
    wr(4'd5, 16'd150);
    wr(4'd0, 16'h0002);
    check(period_err_o == 1'b1, "R8 flag below 200 ns", period_err_o, 1);
    wr(4'd1, 16'd1000);
    wr(4'd3, 16'd40);
    observe(100, 1'b1, h, r, r1, r2, run);
    check(h == 0, "R8 no pulse while illegal", h, 0);
    wr(4'd5, 16'd200);
    check(period_err_o == 1'b0, "R8 200 ns legal", period_err_o, 0);
    observe(20, 1'b1, h, r, r1, r2, run);
    check(h > 0, "R8 pulses once legal", h, 1);
    park();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule